// File: doc/BRIEF.md
# Pause/PFC Transmit Request Controller

This block watches flow control requests for up to eight priority queues and decides when the transmitter must send an XOFF or an XON frame. Each queue's request comes either from register fields or from two input pins. A single mode input chooses how the request is encoded. In 1-bit mode it is a level whose transitions matter. In 2-bit mode it is an explicit XON/XOFF code. While a queue stays paused, the block sends its XOFF frame again after a programmable number of quanta ticks. Requests that are pending together are combined into one frame.

The block does not build frame bytes. It presents a descriptor and holds it until the frame builder returns a done pulse. The descriptor holds the frame kind (classic Pause or priority-based), a class-enable vector, the quanta for each class, and the destination and source addresses. All configuration arrives as input ports from an external register block, which also supplies the reset defaults: enables all ones, quanta and hold 0xFFFF, destination 01-80-C2-00-00-01.

Top module: `pfc_req_ctrl`

## Requirements
- R1: After reset `frame_valid` is low, and no descriptor is presented until a request event occurs.
- R2: A queue whose `q_enable` bit is 0 produces no frame. Pending state for a queue is dropped when its enable bit goes to 0, even if a frame for another queue is in flight.
- R3: In 1-bit mode (`two_bit_mode`=0), a 0-to-1 change of the queue's request bit gives one XOFF frame. Holding the bit at 1 gives no further frame without hold ticks. A 1-to-0 change gives one XON frame.
- R4: In 2-bit mode the code {hi,lo} is read as follows. 10 requests XOFF. 01 requests XON, and only for a queue that is currently paused. 00 and 11 cause nothing.
- R5: `use_reg[q]`=1 takes queue q's request bits from `reg_req_lo`/`reg_req_hi`. `use_reg[q]`=0 takes them from `pin_req_lo`/`pin_req_hi`. The unselected source has no effect.
- R6: Each class sent as XOFF carries that queue's 16-bit field of `xoff_quanta` (bits q*16+15:q*16). Classes sent as XON carry 0, and so does every class not in the frame.
- R7: While a queue stays paused, its XOFF is sent again on the H-th `quanta_tick` after its previous XOFF frame completed, where H is the queue's `hold_quanta` field.
- R8: All queues pending when a frame is issued go into one priority-based descriptor, with one `frame_classes` bit per queue.
- R9: With `pfc_select`=0, a pending queue 0 is sent first and alone, as a classic Pause frame (`frame_is_pfc`=0, classes=0x01). Other queues follow in a priority-based frame.
- R10: The descriptor stays stable while `frame_valid` is high and `frame_done` is low. The cycle after `frame_done`, `frame_valid` is low. The sent requests are then cleared, so no duplicate frame is sent.
- R11: `frame_dst` equals {`dst_hi`,`dst_lo`} and `frame_src` equals {`src_hi`,`src_lo`}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_enable | input | 8 | Per-queue flow control enable |
| two_bit_mode | input | 1 | 0: 1-bit level requests, 1: 2-bit code requests |
| use_reg | input | 8 | Per-queue source: 1 register fields, 0 pins |
| reg_req_lo | input | 8 | Register request, lower bit (the 1-bit request in 1-bit mode) |
| reg_req_hi | input | 8 | Register request, upper bit |
| pin_req_lo | input | 8 | Pin request, lower bit |
| pin_req_hi | input | 8 | Pin request, upper bit |
| pfc_select | input | 1 | 1: queue 0 uses priority frames, 0: classic Pause |
| xoff_quanta | input | 128 | Per-queue XOFF quanta, 16 bits each |
| hold_quanta | input | 128 | Per-queue XOFF repeat interval in ticks |
| dst_lo | input | 32 | Destination address, low 32 bits |
| dst_hi | input | 16 | Destination address, high 16 bits |
| src_lo | input | 32 | Source address, low 32 bits |
| src_hi | input | 16 | Source address, high 16 bits |
| quanta_tick | input | 1 | One pulse per pause quantum |
| frame_valid | output | 1 | Descriptor present |
| frame_is_pfc | output | 1 | 1 priority-based frame, 0 classic Pause |
| frame_classes | output | 8 | Class-enable vector |
| frame_quanta | output | 128 | Per-class quanta |
| frame_dst | output | 48 | Destination address |
| frame_src | output | 48 | Source address |
| frame_done | input | 1 | Frame builder has consumed the descriptor |

## Verification
A wrong paused flag or a wrong pending flag shows at the ports as an extra frame or a missing frame. The descriptor appears two clock edges after the input change that should cause it. It can also appear later, after a `frame_done`, when another frame is already in flight. A hold counter that is off by one shows up as a repeated XOFF that arrives one tick early or one tick late. A stale in-flight mask shows up as a duplicate descriptor, presented the cycle after the done handshake.

// File: rtl/pfc_req_ctrl.sv
module pfc_req_ctrl #(
  parameter int NQ = 8,
  parameter int QW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    q_enable,
  input  logic             two_bit_mode,
  input  logic [NQ-1:0]    use_reg,
  input  logic [NQ-1:0]    reg_req_lo,
  input  logic [NQ-1:0]    reg_req_hi,
  input  logic [NQ-1:0]    pin_req_lo,
  input  logic [NQ-1:0]    pin_req_hi,
  input  logic             pfc_select,
  input  logic [NQ*QW-1:0] xoff_quanta,
  input  logic [NQ*QW-1:0] hold_quanta,
  input  logic [31:0]      dst_lo,
  input  logic [15:0]      dst_hi,
  input  logic [31:0]      src_lo,
  input  logic [15:0]      src_hi,
  input  logic             quanta_tick,
  output logic             frame_valid,
  output logic             frame_is_pfc,
  output logic [NQ-1:0]    frame_classes,
  output logic [NQ*QW-1:0] frame_quanta,
  output logic [47:0]      frame_dst,
  output logic [47:0]      frame_src,
  input  logic             frame_done
);

  logic [NQ-1:0] lo, hi, go_off, go_on;
  logic [NQ-1:0] paused, pend_off, pend_on, sent_off, sent_on;
  logic [NQ-1:0] pend_any, pick;
  logic [QW-1:0] hold_cnt [NQ];
  logic          pause_pick, done_now;

  assign lo = (use_reg & reg_req_lo) | (~use_reg & pin_req_lo);
  assign hi = (use_reg & reg_req_hi) | (~use_reg & pin_req_hi);

  assign go_off = q_enable & ~paused & (two_bit_mode ? (hi & ~lo) : lo);
  assign go_on  = q_enable &  paused & (two_bit_mode ? (lo & ~hi) : ~lo);

  assign pend_any   = pend_off | pend_on;
  assign pause_pick = !pfc_select && pend_any[0];
  assign pick       = pause_pick ? NQ'(1) : pend_any;
  assign done_now   = frame_valid && frame_done;

  assign frame_dst = {dst_hi, dst_lo};
  assign frame_src = {src_hi, src_lo};

  always_ff @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (!rst_n || !q_enable[q]) begin
        paused[q]   <= 1'b0;
        pend_off[q] <= 1'b0;
        pend_on[q]  <= 1'b0;
        hold_cnt[q] <= '0;
      end else if (go_off[q]) begin
        paused[q]   <= 1'b1;
        pend_off[q] <= 1'b1;
        pend_on[q]  <= 1'b0;
        hold_cnt[q] <= hold_quanta[q*QW +: QW];
      end else if (go_on[q]) begin
        paused[q]   <= 1'b0;
        pend_on[q]  <= 1'b1;
        pend_off[q] <= 1'b0;
      end else begin
        if (done_now && sent_off[q]) pend_off[q] <= 1'b0;
        if (done_now && sent_on[q])  pend_on[q]  <= 1'b0;
        if (paused[q] && !pend_off[q] && quanta_tick) begin
          if (hold_cnt[q] <= QW'(1)) begin
            pend_off[q] <= 1'b1;
            hold_cnt[q] <= hold_quanta[q*QW +: QW];
          end else begin
            hold_cnt[q] <= hold_cnt[q] - QW'(1);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_valid   <= 1'b0;
      frame_is_pfc  <= 1'b1;
      frame_classes <= '0;
      frame_quanta  <= '0;
      sent_off      <= '0;
      sent_on       <= '0;
    end else if (done_now) begin
      frame_valid <= 1'b0;
    end else if (!frame_valid && |pick) begin
      frame_valid   <= 1'b1;
      frame_is_pfc  <= !pause_pick;
      frame_classes <= pick;
      sent_off      <= pick & pend_off;
      sent_on       <= pick & pend_on;
      for (int q = 0; q < NQ; q++)
        frame_quanta[q*QW +: QW] <= (pick[q] && pend_off[q]) ? xoff_quanta[q*QW +: QW] : '0;
    end
  end

  assert_desc_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !frame_done |=> frame_valid && $stable(frame_classes) && $stable(frame_quanta) && $stable(frame_is_pfc));

  assert_done_drops_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && frame_done |=> !frame_valid);

  assert_classes_nonempty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> frame_classes != '0);

  assert_pause_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid && !frame_is_pfc |-> frame_classes == NQ'(1));

  assert_disabled_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_valid) |-> (frame_classes & ~$past(q_enable, 2)) == '0);

  for (genvar g = 0; g < NQ; g++) begin : g_chk
    assert_idle_quanta_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid && !frame_classes[g] |-> frame_quanta[g*QW +: QW] == '0);
  end

endmodule

// File: tb/sim_pfc_req_ctrl.sv
module sim_pfc_req_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 8;
  localparam int QW = 16;

  logic clk = 0, rst_n = 0;
  logic [NQ-1:0] q_enable = '1, use_reg = '0;
  logic [NQ-1:0] reg_req_lo = '0, reg_req_hi = '0, pin_req_lo = '0, pin_req_hi = '0;
  logic two_bit_mode = 0, pfc_select = 1, quanta_tick = 0, frame_done = 0;
  logic [NQ*QW-1:0] xoff_quanta, hold_quanta;
  logic [31:0] dst_lo = 32'hC200_0001, src_lo = 32'h5678_9ABC;
  logic [15:0] dst_hi = 16'h0180, src_hi = 16'h1234;
  logic frame_valid, frame_is_pfc;
  logic [NQ-1:0] frame_classes;
  logic [NQ*QW-1:0] frame_quanta;
  logic [47:0] frame_dst, frame_src;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_req_ctrl #(.NQ(NQ), .QW(QW)) u0 (
    .clk, .rst_n, .q_enable, .two_bit_mode, .use_reg, .reg_req_lo, .reg_req_hi,
    .pin_req_lo, .pin_req_hi, .pfc_select, .xoff_quanta, .hold_quanta,
    .dst_lo, .dst_hi, .src_lo, .src_hi, .quanta_tick, .frame_valid, .frame_is_pfc,
    .frame_classes, .frame_quanta, .frame_dst, .frame_src, .frame_done);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [NQ*QW-1:0] qexp(input logic [NQ-1:0] cls, input logic [NQ-1:0] offm);
    logic [NQ*QW-1:0] r = '0;
    for (int q = 0; q < NQ; q++)
      if (cls[q] && offm[q]) r[q*QW +: QW] = QW'(16'h0100 + q);
    return r;
  endfunction

  task automatic expect_frame(input bit pfc, input logic [NQ-1:0] cls,
                              input logic [NQ-1:0] offm, input string req);
    int w = 0;
    logic [NQ-1:0] held;
    while (!frame_valid && w < 20) begin @(negedge clk); w++; end
    chk(frame_valid, req, "frame_valid", 128'(frame_valid), 1);
    if (frame_valid) begin
      chk(frame_is_pfc == pfc, req, "frame_is_pfc", 128'(frame_is_pfc), 128'(pfc));
      chk(frame_classes == cls, req, "frame_classes", 128'(frame_classes), 128'(cls));
      chk(frame_quanta == qexp(cls, offm), req, "frame_quanta R6", frame_quanta, qexp(cls, offm));
      chk(frame_dst == 48'h0180_C200_0001 && frame_src == 48'h1234_5678_9ABC, "R11",
          "addresses", {frame_dst, frame_src}, {48'h0180_C200_0001, 48'h1234_5678_9ABC});
      held = frame_classes;
      @(negedge clk);
      chk(frame_valid && frame_classes == held, "R10", "descriptor held", 128'(frame_classes), 128'(held));
      frame_done = 1;
      @(negedge clk);
      frame_done = 0;
      chk(!frame_valid, "R10", "valid after done", 128'(frame_valid), 0);
    end
  endtask

  task automatic expect_none(input int n, input string req);
    bit seen = 0;
    repeat (n) begin @(negedge clk); if (frame_valid) seen = 1; end
    chk(!seen, req, "unexpected frame", 128'(frame_classes), 0);
  endtask

  task automatic tick();
    quanta_tick = 1; @(negedge clk); quanta_tick = 0;
  endtask

  task automatic t_reset();
    chk(!frame_valid, "R1", "valid after reset", 128'(frame_valid), 0);
    expect_none(6, "R1");
  endtask

  task automatic t_one_bit();
    pin_req_lo[2] = 1; expect_frame(1, 8'h04, 8'h04, "R3");
    expect_none(6, "R3");
    pin_req_lo[2] = 0; expect_frame(1, 8'h04, 8'h00, "R3");
    expect_none(4, "R3");
  endtask

  task automatic t_source_1bit();
    use_reg[4] = 1; pin_req_lo[4] = 1; expect_none(5, "R5");
    reg_req_lo[4] = 1; expect_frame(1, 8'h10, 8'h10, "R5");
    reg_req_lo[4] = 0; expect_frame(1, 8'h10, 8'h00, "R5");
    pin_req_lo[4] = 0; use_reg[4] = 0; expect_none(4, "R5");
  endtask

  task automatic t_hold();
    pin_req_lo[3] = 1; expect_frame(1, 8'h08, 8'h08, "R7");
    tick(); tick(); expect_none(4, "R7");
    tick(); expect_frame(1, 8'h08, 8'h08, "R7");
    pin_req_lo[3] = 0; expect_frame(1, 8'h08, 8'h00, "R7");
    tick(); tick(); tick(); tick(); expect_none(4, "R7");
  endtask

  task automatic t_two_bit();
    two_bit_mode = 1; use_reg[1] = 1;
    reg_req_lo[1] = 1; expect_none(5, "R4");
    reg_req_lo[1] = 0; reg_req_hi[1] = 1; expect_frame(1, 8'h02, 8'h02, "R4");
    reg_req_lo[1] = 1; expect_none(5, "R4");
    reg_req_lo[1] = 0; reg_req_hi[1] = 0; expect_none(5, "R4");
    reg_req_lo[1] = 1; expect_frame(1, 8'h02, 8'h00, "R4");
    reg_req_lo[1] = 0;
    reg_req_hi[5] = 1; expect_none(5, "R5");
    pin_req_hi[5] = 1; expect_frame(1, 8'h20, 8'h20, "R5");
    pin_req_hi[5] = 0; pin_req_lo[5] = 1; expect_frame(1, 8'h20, 8'h00, "R5");
    pin_req_lo[5] = 0; reg_req_hi[5] = 0; use_reg[1] = 0; two_bit_mode = 0;
    expect_none(4, "R4");
  endtask

  task automatic t_enable();
    q_enable[4] = 0; pin_req_lo[4] = 1; expect_none(6, "R2");
    pin_req_lo[4] = 0; @(negedge clk); q_enable[4] = 1; expect_none(4, "R2");
    pin_req_lo[7] = 1;
    while (!frame_valid) @(negedge clk);
    pin_req_lo[6] = 1; @(negedge clk);
    q_enable[6] = 0; pin_req_lo[6] = 0; @(negedge clk);
    expect_frame(1, 8'h80, 8'h80, "R2");
    expect_none(6, "R2");
    q_enable[6] = 1;
    pin_req_lo[7] = 0; expect_frame(1, 8'h80, 8'h00, "R2");
  endtask

  task automatic t_merge();
    pin_req_lo[1] = 1;
    while (!frame_valid) @(negedge clk);
    pin_req_lo[2] = 1; @(negedge clk);
    pin_req_lo[6] = 1; @(negedge clk);
    expect_frame(1, 8'h02, 8'h02, "R8");
    expect_frame(1, 8'h44, 8'h44, "R8");
    pin_req_lo[1] = 0; pin_req_lo[2] = 0; pin_req_lo[6] = 0;
    expect_frame(1, 8'h46, 8'h00, "R8");
    expect_none(4, "R8");
  endtask

  task automatic t_pause();
    pfc_select = 0;
    pin_req_lo[0] = 1; pin_req_lo[5] = 1;
    expect_frame(0, 8'h01, 8'h01, "R9");
    expect_frame(1, 8'h20, 8'h20, "R9");
    pin_req_lo[0] = 0; pin_req_lo[5] = 0;
    expect_frame(0, 8'h01, 8'h00, "R9");
    expect_frame(1, 8'h20, 8'h00, "R9");
    pfc_select = 1;
    pin_req_lo[0] = 1; pin_req_lo[5] = 1;
    expect_frame(1, 8'h21, 8'h21, "R9");
    pin_req_lo[0] = 0; pin_req_lo[5] = 0;
    expect_frame(1, 8'h21, 8'h00, "R9");
  endtask

  initial begin
    for (int q = 0; q < NQ; q++) begin
      xoff_quanta[q*QW +: QW] = QW'(16'h0100 + q);
      hold_quanta[q*QW +: QW] = QW'(3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_one_bit();
    t_source_1bit();
    t_hold();
    t_two_bit();
    t_enable();
    t_merge();
    t_pause();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule